// File: doc/BRIEF.md
# Carrier Phase Error Detector

This block turns the angle word produced by a rectangular-to-polar stage into a scaled carrier phase error for a tracking loop. Each qualified sample has a programmable coarse rotation added to it. The sum wraps around at one full turn and never saturates. The wrapped angle is then multiplied by a power of two through a left shift. Bits shifted past the top are lost, and zeros fill in from the bottom.

The angle input is a 16-bit two's complement word. Its full scale covers -π up to just below +π, so a step of 1 LSB is π/32768.

The rotation is a 4-bit two's complement fraction of π. It carries a sign weight of -1 and fraction weights of 1/2, 1/4 and 1/8. It sits on the top four bits of the angle word. Code 0111 therefore rotates by +7π/8, code 1000 rotates by -π, and each code step is 22.5 degrees.

The 2-bit gain field selects a shift of 0, 1, 2 or 3 places. Both control fields are treated as quasi-static settings. They are read together with each valid sample, so a change applies from the next qualified sample onward. The result is registered, with one cycle from input qualifier to output qualifier.

Top module: `carrier_phase_err`

## Requirements
- R1: While reset is asserted and in the first cycle after it, errValid is 0 and errOut is 0x0000.
- R2: errValid is high in exactly those cycles that follow a clock edge at which phaseValid was high.
- R3: With gain code 0, errOut equals (phaseIn + rotCode·4096) mod 65536, where rotCode is the 4-bit rotation taken as two's complement. For example, code 0111 applied to angle 0x0000 gives 0x7000.
- R4: The rotation sum wraps modulo 2^16 without saturation. For example, 0x7FFF with code 0001 gives 0x8FFF, and 0x8000 with code 1111 gives 0x7000.
- R5: Code 1000 rotates by -π, which is the same as adding 0x8000. For example, 0x1234 gives 0x9234.
- R6: Gain code g (0 to 3) shifts the wrapped sum left by g places. The top g bits are dropped and the low g bits become 0. For example, 0xFFFF with code 3 gives 0xFFF8, and 0x4001 with code 1 gives 0x8002.
- R7: When phaseValid is low, errOut keeps its previous value, whatever happens on phaseIn, rotCode and gainSel.
- R8: rotCode and gainSel are taken at the same clock edge as the qualified sample. A setting changed between samples applies to the very next valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| phaseValid | input | 1 | Qualifies phaseIn |
| phaseIn | input | 16 | Two's complement angle, full scale ±π |
| rotCode | input | 4 | Coarse rotation, two's complement fraction of π |
| gainSel | input | 2 | Left shift amount, 0 to 3 |
| errValid | output | 1 | Qualifies errOut |
| errOut | output | 16 | Rotated and scaled phase error |

## Verification
The assertions assume that rotCode and gainSel are known whenever phaseValid is high. They also assume that phaseValid is held low throughout reset, so the first cycle after reset carries no stale qualifier.

The bench changes the settings only on falling edges. It keeps the qualifier low during reset. Settings are always driven with defined values, including in idle cycles. Because of this, every qualified edge sees a stable angle, rotation and gain.

// File: rtl/cped_pkg.sv
package cped_pkg;
  // Strobes sent from the sequencing logic to the arithmetic path
  typedef struct packed {
    logic capture;   // load the result register this cycle
    logic clear;     // force the result register to zero
  } cpedStrobe_t;
endpackage

// File: rtl/cped_ctrl.sv
module cped_ctrl
  import cped_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        phaseValid,
  output cpedStrobe_t strobes,
  output logic        errValid
);
  always_comb begin
    strobes.clear   = !rstN;
    strobes.capture = rstN && phaseValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) errValid <= 1'b0;
    else       errValid <= phaseValid;
  end
endmodule

// File: rtl/cped_datapath.sv
module cped_datapath
  import cped_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int ROT_W   = 4,
  parameter int GAIN_W  = 2
) (
  input  logic               clk,
  input  cpedStrobe_t        strobes,
  input  logic [PHASE_W-1:0] phaseIn,
  input  logic [ROT_W-1:0]   rotCode,
  input  logic [GAIN_W-1:0]  gainSel,
  output logic [PHASE_W-1:0] errOut
);
  localparam int PadW = PHASE_W - ROT_W;

  logic [PHASE_W-1:0] rotAligned;
  logic [PHASE_W-1:0] rotated;
  logic [PHASE_W-1:0] stage [GAIN_W+1];

  // Rotation sits on the top bits; the natural overflow of the sum gives the modulo-2π wrap
  assign rotAligned = {rotCode, {PadW{1'b0}}};
  assign rotated    = phaseIn + rotAligned;
  assign stage[0]   = rotated;

  // Logarithmic shifter: stage k shifts by 2^k when gain bit k is set
  for (genvar k = 0; k < GAIN_W; k++) begin : g_shift
    assign stage[k+1] = gainSel[k] ? (stage[k] << (1 << k)) : stage[k];
  end

  always_ff @(posedge clk) begin
    if (strobes.clear)        errOut <= '0;
    else if (strobes.capture) errOut <= stage[GAIN_W];
  end
endmodule

// File: rtl/carrier_phase_err.sv
module carrier_phase_err
  import cped_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int ROT_W   = 4,
  parameter int GAIN_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               phaseValid,
  input  logic [PHASE_W-1:0] phaseIn,
  input  logic [ROT_W-1:0]   rotCode,
  input  logic [GAIN_W-1:0]  gainSel,
  output logic               errValid,
  output logic [PHASE_W-1:0] errOut
);
  cpedStrobe_t strobes;

  cped_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .phaseValid(phaseValid),
    .strobes   (strobes),
    .errValid  (errValid)
  );

  cped_datapath #(
    .PHASE_W(PHASE_W),
    .ROT_W  (ROT_W),
    .GAIN_W (GAIN_W)
  ) u_dp (
    .clk    (clk),
    .strobes(strobes),
    .phaseIn(phaseIn),
    .rotCode(rotCode),
    .gainSel(gainSel),
    .errOut (errOut)
  );
endmodule

// File: rtl/cped_checker.sv
module cped_checker #(
  parameter int PHASE_W = 16,
  parameter int ROT_W   = 4,
  parameter int GAIN_W  = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               phaseValid,
  input logic [PHASE_W-1:0] phaseIn,
  input logic [ROT_W-1:0]   rotCode,
  input logic [GAIN_W-1:0]  gainSel,
  input logic               errValid,
  input logic [PHASE_W-1:0] errOut
);
  localparam int RotLsb = PHASE_W - ROT_W;

  // Independent model: sum as wide integers, scale by multiplication, then truncate
  logic [31:0]        wideSum;
  logic [31:0]        wideScaled;
  logic [PHASE_W-1:0] modelNext;
  always_comb begin
    wideSum    = 32'(phaseIn) + (32'(rotCode) * (32'd1 << RotLsb));
    wideScaled = wideSum * (32'd1 << gainSel);
    modelNext  = wideScaled[PHASE_W-1:0];
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    phaseValid |=> errValid);
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    !phaseValid |=> !errValid);
  assert_result_R3: assert property (@(posedge clk) disable iff (!rstN)
    phaseValid |=> errOut == $past(modelNext));
  assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phaseValid && gainSel != '0) |=> errOut[0] == 1'b0);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !phaseValid |=> $stable(errOut));
  assert_reset_R1: assert property (@(posedge clk)
    !rstN |=> (!errValid && errOut == '0));
endmodule

bind carrier_phase_err cped_checker #(
  .PHASE_W(PHASE_W),
  .ROT_W  (ROT_W),
  .GAIN_W (GAIN_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .phaseValid(phaseValid),
  .phaseIn   (phaseIn),
  .rotCode   (rotCode),
  .gainSel   (gainSel),
  .errValid  (errValid),
  .errOut    (errOut)
);

// File: tb/tb_carrier_phase_err.sv
module tb_carrier_phase_err;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        phaseValid = 1'b0;
  logic [15:0] phaseIn = '0;
  logic [3:0]  rotCode = '0;
  logic [1:0]  gainSel = '0;
  logic        errValid;
  logic [15:0] errOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  carrier_phase_err dut (
    .clk(clk), .rstN(rstN), .phaseValid(phaseValid), .phaseIn(phaseIn),
    .rotCode(rotCode), .gainSel(gainSel), .errValid(errValid), .errOut(errOut)
  );

  // Reference from the requirement text: wrap the sum at 16 bits, then shift and truncate
  function automatic logic [15:0] refErr(input logic [15:0] ph, input logic [3:0] rc,
                                         input logic [1:0] g);
    logic [15:0] s;
    s = ph + {rc, 12'h000};
    return s << g;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  // Present one qualified sample, then check the result one cycle later
  task automatic sendOne(input string req, input logic [15:0] ph, input logic [3:0] rc,
                         input logic [1:0] g, input logic [15:0] exp);
    @(negedge clk);
    phaseValid = 1'b1; phaseIn = ph; rotCode = rc; gainSel = g;
    @(negedge clk);
    phaseValid = 1'b0;
    check("R2", {15'd0, errValid}, 16'd1);
    check(req, errOut, exp);
    check({req, " ref"}, errOut, refErr(ph, rc, g));
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 valid", {15'd0, errValid}, 16'd0);
    check("R1 data", errOut, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after", {15'd0, errValid}, 16'd0);
    check("R1 after data", errOut, 16'h0000);
  endtask

  task automatic testOffset();
    sendOne("R3 +7pi/8", 16'h0000, 4'b0111, 2'd0, 16'h7000);
    sendOne("R3 -pi/8", 16'h0100, 4'b1111, 2'd0, 16'hF100);
    sendOne("R3 zero", 16'h1357, 4'b0000, 2'd0, 16'h1357);
    sendOne("R5 -pi", 16'h1234, 4'b1000, 2'd0, 16'h9234);
    for (int c = 0; c < 16; c++)
      sendOne("R3 sweep", 16'h0ABC, 4'(c), 2'd0, refErr(16'h0ABC, 4'(c), 2'd0));
  endtask

  task automatic testWrap();
    sendOne("R4 up", 16'h7FFF, 4'b0001, 2'd0, 16'h8FFF);
    sendOne("R4 down", 16'h8000, 4'b1111, 2'd0, 16'h7000);
    sendOne("R4 big", 16'hF000, 4'b0111, 2'd0, 16'h6000);
  endtask

  task automatic testShift();
    sendOne("R6 g3", 16'hFFFF, 4'b0000, 2'd3, 16'hFFF8);
    sendOne("R6 g1", 16'h4001, 4'b0000, 2'd1, 16'h8002);
    sendOne("R6 g2", 16'h2345, 4'b0001, 2'd2, 16'hCD14);
    sendOne("R6 rot+g1", 16'h0000, 4'b0111, 2'd1, 16'hE000);
  endtask

  task automatic testHold();
    logic [15:0] held;
    sendOne("R7 prime", 16'h0123, 4'b0010, 2'd0, 16'h2123);
    held = errOut;
    for (int i = 0; i < 5; i++) begin
      phaseIn = 16'hA5A5 ^ 16'(i); rotCode = 4'(i + 3); gainSel = 2'(i);
      @(negedge clk);
      check("R7 hold", errOut, held);
      check("R7 novalid", {15'd0, errValid}, 16'd0);
    end
  endtask

  task automatic testConfigChange();
    sendOne("R8 before", 16'h0010, 4'b0001, 2'd0, 16'h1010);
    @(negedge clk);
    rotCode = 4'b0100; gainSel = 2'd2;
    @(negedge clk);
    sendOne("R8 after", 16'h0010, 4'b0100, 2'd2, 16'h0040);
    // Back-to-back stream with a different setting on each sample
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      phaseValid = 1'b1; phaseIn = 16'h1111 * 16'(i + 1);
      rotCode = 4'(i * 5); gainSel = 2'(3 - i);
      @(negedge clk);
      check("R2 stream", {15'd0, errValid}, 16'd1);
      check("R8 stream", errOut, refErr(16'h1111 * 16'(i + 1), 4'(i * 5), 2'(3 - i)));
    end
    phaseValid = 1'b0;
    @(negedge clk);
    check("R2 drop", {15'd0, errValid}, 16'd0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testOffset();
    testWrap();
    testShift();
    testHold();
    testConfigChange();
    finishRun();
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end
endmodule